// File: doc/BRIEF.md
# Prescaled Reloadable Capture/Compare Timebase

This block is the shared time reference of a capture/compare unit. A 16-bit counter advances once for each terminal count of a 10-bit prescaler. It counts up or down under a direction bit, and it wraps against an active reload value. The compare and capture channels next to it use the live count, a one-cycle overflow pulse and the selected operating mode.

Software writes the reload limit into a shadow copy. A separate update request then moves the shadow into the active register. In basic timer mode the transfer happens on the write itself. In the two PWM modes it waits for the next counter overflow, so a PWM period is never cut short partway through. Every overflow also sets a sticky flag. The flag raises the interrupt line only while the interrupt enable is set, and software clears it by writing a 1.

An 8-bit register port (addresses 0 to 11) gives write and read access to the settings, the pending update bit, the flag and the count.

Top module: `ccu_timebase`

## Requirements
- R1: After reset the count is 0, the overflow flag, interrupt enable, pending update bit, control register and prescale value are all 0, and both the shadow and active reload registers hold 16'hFFFF.
- R2: The prescale value P is taken from address 0 (bits 7:0) and address 1 bits 1:0 (bits 9:8). The count changes only on a prescaler terminal count, which occurs once every P+1 clocks.
- R3: With control bit 0 clear (count up), the count steps up until it equals the active reload R. The next step gives 0 and a one-cycle high pulse on ovf_o, so the overflow period is (R+1)*(P+1) clocks.
- R4: With control bit 0 set (count down), the count steps down to 0. The next step loads R and pulses ovf_o, again giving a period of (R+1)*(P+1) clocks.
- R5: When counting up with the count already above R, the count runs on to 16'hFFFF, then wraps to 0 with an overflow pulse.
- R6: Mode is control bits 2:1, where 00 is basic. In basic mode, writing 1 to bit 0 of address 5 copies the shadow reload (addresses 2 low / 3 high) into the active reload (read at 8 low / 9 high) on that same clock edge, and the pending bit (address 5 read) stays 0.
- R7: In the PWM modes (01 synchronous, 10 asynchronous, 11 treated as PWM), an update request sets the pending bit. The active reload keeps its value until the next overflow. At that overflow it takes the shadow value and the pending bit clears itself.
- R8: Every overflow sets the flag (address 7 bit 0). irq_o equals the flag ANDed with the enable (address 6 bit 0).
- R9: Writing 1 to address 7 bit 0 clears the flag, and writing 0 there has no effect. An overflow in the same cycle as the clear leaves the flag set.
- R10: count_o and addresses 10 (low byte) and 11 (high byte) give the live count, and mode_o gives control bits 2:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Combinational read data |
| count_o | output | 16 | Live counter value for the channels |
| ovf_o | output | 1 | One-cycle overflow/reload pulse |
| mode_o | output | 2 | Selected timer mode |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
A prescaler that is stuck or off by one shows up as a wrong distance between ovf_o pulses at once, in the very next period. An active reload that was committed at the wrong moment shows on the read port in the cycle after the update write. In PWM mode the same fault changes the following period, so it is visible within one overflow. A flag that is mishandled shows on irq_o and the flag read in the cycle after the overflow or clear that exposes it, and the collision case checks which of set and clear wins.

// File: rtl/ctb_pkg.sv
// Package: shared widths, mode codes and register addresses of the timebase.
// Assumes an 8-bit register port and a counter no wider than 16 bits.
package ctb_pkg;
    localparam int CNT_W  = 16;
    localparam int PRE_W  = 10;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        MODE_BASIC     = 2'b00,
        MODE_PWM_SYNC  = 2'b01,
        MODE_PWM_ASYNC = 2'b10,
        MODE_PWM_RSVD  = 2'b11
    } tb_mode_e;

    localparam logic [ADDR_W-1:0] A_PRE_LO = 4'd0;
    localparam logic [ADDR_W-1:0] A_PRE_HI = 4'd1;
    localparam logic [ADDR_W-1:0] A_SHD_LO = 4'd2;
    localparam logic [ADDR_W-1:0] A_SHD_HI = 4'd3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd4;
    localparam logic [ADDR_W-1:0] A_UPD    = 4'd5;
    localparam logic [ADDR_W-1:0] A_IEN    = 4'd6;
    localparam logic [ADDR_W-1:0] A_FLAG   = 4'd7;
    localparam logic [ADDR_W-1:0] A_ACT_LO = 4'd8;
    localparam logic [ADDR_W-1:0] A_ACT_HI = 4'd9;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 4'd10;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 4'd11;
endpackage

// File: rtl/ctb_prescaler.sv
// Prescaler: issues a one-cycle tick every (pre_val+1) clocks.
// Assumes pre_val may change at any time; a count at or above it restarts.
module ctb_prescaler #(
    parameter int PRE_W = ctb_pkg::PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] pre_val,
    output logic             tick
);
    logic [PRE_W-1:0] pre_cnt;

    assign tick = (pre_cnt >= pre_val);

    // Purpose: advance the divider and restart it on terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)     pre_cnt <= '0;
        else if (tick)  pre_cnt <= '0;
        else            pre_cnt <= pre_cnt + 1'b1;
    end

    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pre_cnt == '0)); // R2
endmodule

// File: rtl/ctb_counter.sv
// Counter core: steps up or down on each tick and wraps against the reload.
// Up: after reaching reload (or all-ones) goes to 0. Down: after 0 loads reload.
// Assumes reload is stable for the cycle in which it is used.
module ctb_counter #(
    parameter int CNT_W = ctb_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             down,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_evt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic at_limit;

    // Purpose: decide whether the next step is a wrap.
    always_comb begin
        if (down) at_limit = (cnt == '0);
        else      at_limit = (cnt == reload) || (cnt == ALL_ONES);
        wrap_evt = tick && at_limit;
    end

    // Purpose: step the count and register the overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            ovf <= wrap_evt;
            if (tick) begin
                if (at_limit) cnt <= down ? reload : '0;
                else          cnt <= down ? cnt - 1'b1 : cnt + 1'b1;
            end
        end
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt)); // R2
    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !down && cnt == reload) |=> (cnt == '0) && ovf); // R3
    AST_DOWN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && down && cnt == '0) |=> (cnt == $past(reload)) && ovf); // R4
endmodule

// File: rtl/ctb_regs.sv
// Register file: prescale, shadow/active reload, control, enable and flag.
// Commits shadow to active at once in basic mode, at overflow in PWM modes.
// Assumes wrap_evt comes from the counter in the same cycle as the wrap edge.
module ctb_regs #(
    parameter int CNT_W  = ctb_pkg::CNT_W,
    parameter int PRE_W  = ctb_pkg::PRE_W,
    parameter int DATA_W = ctb_pkg::DATA_W,
    parameter int ADDR_W = ctb_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wrap_evt,
    input  logic [CNT_W-1:0]  cnt,
    output logic [PRE_W-1:0]  pre_val,
    output logic [CNT_W-1:0]  reload,
    output logic              down,
    output logic [1:0]        mode,
    output logic              irq
);
    import ctb_pkg::*;

    localparam int PRE_HI_W = PRE_W - DATA_W;
    localparam int CNT_HI_W = CNT_W - DATA_W;

    logic [CNT_W-1:0] shadow;
    logic [2:0]       ctrl;
    logic             ien, flag, pend;
    logic             upd_req, flag_clr, is_basic, req, commit;

    assign down     = ctrl[0];
    assign mode     = ctrl[2:1];
    assign is_basic = (ctrl[2:1] == MODE_BASIC);
    assign upd_req  = wr_en && (wr_addr == A_UPD) && wr_data[0];
    assign flag_clr = wr_en && (wr_addr == A_FLAG) && wr_data[0];
    assign req      = upd_req || pend;
    assign commit   = req && (is_basic || wrap_evt);
    assign irq      = flag && ien;

    // Purpose: software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_val <= '0;
            shadow  <= '1;
            ctrl    <= '0;
            ien     <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                A_PRE_LO: pre_val[DATA_W-1:0]     <= wr_data;
                A_PRE_HI: pre_val[PRE_W-1:DATA_W] <= wr_data[PRE_HI_W-1:0];
                A_SHD_LO: shadow[DATA_W-1:0]      <= wr_data;
                A_SHD_HI: shadow[CNT_W-1:DATA_W]  <= wr_data[CNT_HI_W-1:0];
                A_CTRL:   ctrl                    <= wr_data[2:0];
                A_IEN:    ien                     <= wr_data[0];
                default:  ;
            endcase
        end
    end

    // Purpose: move shadow to active reload and track a pending request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '1;
            pend   <= 1'b0;
        end else begin
            pend <= req && !commit;
            if (commit) reload <= shadow;
        end
    end

    // Purpose: sticky overflow flag, set wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (wrap_evt) flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    // Purpose: combinational read mux.
    always_comb begin
        case (rd_addr)
            A_PRE_LO: rd_data = pre_val[DATA_W-1:0];
            A_PRE_HI: rd_data = DATA_W'(pre_val[PRE_W-1:DATA_W]);
            A_SHD_LO: rd_data = shadow[DATA_W-1:0];
            A_SHD_HI: rd_data = DATA_W'(shadow[CNT_W-1:DATA_W]);
            A_CTRL:   rd_data = DATA_W'(ctrl);
            A_UPD:    rd_data = DATA_W'(pend);
            A_IEN:    rd_data = DATA_W'(ien);
            A_FLAG:   rd_data = DATA_W'(flag);
            A_ACT_LO: rd_data = reload[DATA_W-1:0];
            A_ACT_HI: rd_data = DATA_W'(reload[CNT_W-1:DATA_W]);
            A_CNT_LO: rd_data = cnt[DATA_W-1:0];
            A_CNT_HI: rd_data = DATA_W'(cnt[CNT_W-1:DATA_W]);
            default:  rd_data = '0;
        endcase
    end

    AST_BASIC_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && is_basic) |=> (reload == $past(shadow)) && !pend); // R6
    AST_PWM_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !is_basic && !wrap_evt) |=> $stable(reload) && pend); // R7
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> flag); // R8
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !wrap_evt) |=> !flag); // R9
endmodule

// File: rtl/ccu_timebase.sv
// Top: prescaled up/down 16-bit timebase with shadowed reload and overflow flag.
// Assumes a single clock domain; the register port is written one access per cycle.
module ccu_timebase #(
    parameter int CNT_W  = ctb_pkg::CNT_W,
    parameter int PRE_W  = ctb_pkg::PRE_W,
    parameter int DATA_W = ctb_pkg::DATA_W,
    parameter int ADDR_W = ctb_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count_o,
    output logic              ovf_o,
    output logic [1:0]        mode_o,
    output logic              irq_o
);
    logic [PRE_W-1:0] pre_val;
    logic [CNT_W-1:0] reload;
    logic             tick, down, wrap_evt;

    ctb_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .pre_val(pre_val), .tick(tick)
    );

    ctb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .down(down), .reload(reload),
        .cnt(count_o), .wrap_evt(wrap_evt), .ovf(ovf_o)
    );

    ctb_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .wrap_evt(wrap_evt), .cnt(count_o), .pre_val(pre_val),
        .reload(reload), .down(down), .mode(mode_o), .irq(irq_o)
    );
endmodule

// File: tb/tb_ccu_timebase.sv
module tb_ccu_timebase;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [15:0] count_o;
    logic       ovf_o, irq_o;
    logic [1:0] mode_o;
    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    ccu_timebase dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .count_o(count_o), .ovf_o(ovf_o), .mode_o(mode_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        rd_addr = 4'(a);
        #1;
        v = int'(rd_data);
    endtask

    task automatic wait_ovf(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ovf_o && n < 150000);
    endtask

    task automatic config_tb(input int p, input int r, input int dn);
        int n;
        wr(1, 3); wr(0, 255);
        wr(4, 1);
        wr(2, r & 255); wr(3, r >> 8); wr(5, 1);
        wr(0, p & 255); wr(1, p >> 8);
        wait_ovf(n);
        wr(4, dn);
        wait_ovf(n);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int v, n, c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state (rd during first cycle after reset release)
        rd(8, v); chk("R1 active lo", v, 255);
        rd(9, v); chk("R1 active hi", v, 255);
        rd(3, v); chk("R1 shadow hi", v, 255);
        rd(7, v); chk("R1 flag", v, 0);
        rd(5, v); chk("R1 pend", v, 0);
        rd(4, v); chk("R1 ctrl", v, 0);
        rd(0, v); chk("R1 pre lo", v, 0);
        chk("R1 irq", int'(irq_o), 0);

        // R2 R3 R4: period sweep over prescale, reload and direction
        for (int dn = 0; dn < 2; dn++)
            for (int p = 0; p < 4; p++)
                for (int r = 1; r < 5; r++) begin
                    config_tb(p, r, dn);
                    chk(dn ? "R4 count at ovf" : "R3 count at ovf",
                        int'(count_o), dn ? r : 0);
                    wait_ovf(n);
                    chk(dn ? "R4 R2 period" : "R3 R2 period", n, (r + 1) * (p + 1));
                    @(negedge clk);
                    if (p > 0) chk("R3 pulse width", int'(ovf_o), 0);
                end

        // R10: count bytes and mode output
        config_tb(0, 300, 1);
        rd(10, v); chk("R10 count lo", v, 300 & 255);
        rd(11, v); chk("R10 count hi", v, 300 >> 8);
        chk("R10 count_o", int'(count_o), 300);

        // R7: deferred commit in both PWM modes
        for (int m = 1; m < 3; m++) begin
            config_tb(3, 7, 0);
            wr(4, m << 1);
            chk("R10 mode_o", int'(mode_o), m);
            wait_ovf(n);
            wr(2, 2); wr(3, 0); wr(5, 1);
            rd(8, v); chk("R7 active held", v, 7);
            rd(5, v); chk("R7 pend set", v, 1);
            wait_ovf(n);
            chk("R7 old period", n > 0 && n <= 32 ? 1 : 0, 1);
            rd(8, v); chk("R7 active committed", v, 2);
            rd(5, v); chk("R7 pend cleared", v, 0);
            wait_ovf(n);
            chk("R7 new period", n, 12);
        end

        // R6: immediate commit in basic mode
        config_tb(3, 7, 0);
        wr(2, 5); wr(3, 0); wr(5, 1);
        rd(8, v); chk("R6 active now", v, 5);
        rd(5, v); chk("R6 pend", v, 0);

        // R8 R9: flag, enable and clear
        config_tb(50, 3, 0);
        rd(7, v); chk("R8 flag set", v, 1);
        chk("R8 irq masked", int'(irq_o), 0);
        wr(6, 1);
        chk("R8 irq enabled", int'(irq_o), 1);
        wr(7, 0);
        rd(7, v); chk("R9 write zero ignored", v, 1);
        wr(7, 1);
        rd(7, v); chk("R9 flag cleared", v, 0);
        chk("R9 irq cleared", int'(irq_o), 0);
        config_tb(0, 20, 0);
        wr(7, 1);
        n = 0;
        while (count_o != 16'd20 && n < 100) begin @(negedge clk); n++; end
        wr_en = 1'b1; wr_addr = 4'd7; wr_data = 8'd1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9 collision ovf", int'(ovf_o), 1);
        rd(7, v); chk("R9 set wins", v, 1);

        // R5: count above reload runs to all-ones
        config_tb(0, 10, 0);
        wr(2, 3); wr(3, 0);
        n = 0;
        while (count_o != 16'd8 && n < 100) begin @(negedge clk); n++; end
        wr(5, 1);
        c0 = int'(count_o);
        wait_ovf(n);
        chk("R5 cycles to wrap", n, 65536 - c0);
        chk("R5 count wrapped", int'(count_o), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule